// File: doc/BRIEF.md
# Channel-to-Line Crosspoint Selection Controller

This block manages a switching matrix that links a small set of communication channels to a larger set of two-wire terminal lines. With the default parameters there are four channels and 32 lines, and the lines are grouped eight to a board. The block keeps one connection bit for every channel and line pair. Each bit behaves like a self-holding switch: a connection is made by one selection word with an On strobe, and it stays made until the whole channel is released by its channel-off strobe. A single connection cannot be released by itself. A line may belong to at most one channel. An On order that would give a line to a second channel is refused, and a sticky error flag records the refusal.

For every accepted On order, the block pulses one board enable, one line-within-board enable and one channel select for a single cycle. These pulses drive the physical switch. The block also produces the line-driver enables. While a channel requests to send, every line connected to it transmits, except the line that is currently sending into the channel. This exception lets one terminal's traffic be repeated to the other terminals on the same channel. The sending line for each channel is identified from per-line carrier-detect inputs.

Top module: `xpt_ctrl`

## Requirements
- R1: After reset all connection bits, selection pulses, the error flag, the source indications and the driver enables are zero.
- R2: An On strobe with selection word bits [6:5] = channel, [4:3] = board and [2:0] = position connects line board*8+position to that channel. The connection appears on conn_o bit channel*32+line in the cycle after the strobe.
- R3: In the cycle after an accepted On, brd_en_o has only bit board set, lin_en_o has only bit position set and ch_sel_o has only bit channel set. In every other cycle all three are zero.
- R4: A connection stays after the On strobe is withdrawn, and further On orders add to the connections already made.
- R5: Asserting ch_off_i[c] clears every connection of channel c in the next cycle and leaves other channels untouched. An On order for channel c in the same cycle is discarded: it gives no pulse, no connection and no error.
- R6: An On order for a line held by another channel (judged on the registered state) is refused. The connections stay unchanged, no pulse is given, and err_o rises in the next cycle and stays high until reset. A repeated On for a line the same channel already holds is accepted without error.
- R7: drv_en_o[i] is high, in the same cycle as rts_i, exactly when line i is connected to a channel c with rts_i[c] high and line i is not the current source of c.
- R8: A channel without a source takes as source the lowest-numbered connected line with cd_i high, in the next cycle. The source is held while that line's carrier stays high. It is released in the cycle after the carrier drops, and a new choice is made one cycle later. A channel-off also releases the source.
- R9: Channels work independently: several channels can hold lines, sources and active send requests at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_on_i | input | 1 | On strobe for the selection word |
| sel_word_i | input | 7 | Selection word {channel, board, position} |
| ch_off_i | input | 4 | Per-channel release strobe |
| rts_i | input | 4 | Per-channel request to send |
| cd_i | input | 32 | Per-line carrier detect |
| conn_o | output | 128 | Connection bits, bit channel*32+line |
| err_o | output | 1 | Sticky refused-order flag |
| brd_en_o | output | 4 | One-cycle board enable pulse |
| lin_en_o | output | 8 | One-cycle line-within-board enable pulse |
| ch_sel_o | output | 4 | One-cycle channel select pulse |
| drv_en_o | output | 32 | Line-driver enables |
| src_valid_o | output | 4 | Channel has an identified sending line |
| src_line_o | output | 20 | Sending line per channel, 5 bits each |

## Verification
The hardest situation to reach is the handover of the sending line while a channel is requesting to send. Two connected lines must carry carrier at once, so that the lower one is chosen. The chosen line's carrier must then drop while the other carrier stays high. This exercises both the release cycle, in which every connected line drives, and the re-selection of the other line one cycle later. The stimulus builds this step by step: it connects two lines, raises both carriers in one cycle, and then withdraws one carrier. The driver pattern is checked in each of the three cycles. A second hard case is an On order that arrives in the same cycle as the channel-off strobe for its own channel. It is driven explicitly, and the check confirms that the order is dropped silently.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    typedef enum logic [1:0] {
        ON_NONE   = 2'd0,
        ON_ACCEPT = 2'd1,
        ON_REJECT = 2'd2,
        ON_DROP   = 2'd3
    } on_res_e;
endpackage

// File: rtl/xpt_sel_decode.sv
module xpt_sel_decode #(
    parameter int NUM_CH  = 4,
    parameter int NUM_BRD = 4,
    parameter int LPB     = 8,
    localparam int CW     = $clog2(NUM_CH),
    localparam int BW     = $clog2(NUM_BRD),
    localparam int PW     = $clog2(LPB),
    localparam int LW     = BW + PW,
    localparam int WW     = CW + BW + PW
) (
    input  logic [WW-1:0]      sel_word_i,
    output logic [CW-1:0]      ch_idx_o,
    output logic [LW-1:0]      line_idx_o,
    output logic [NUM_CH-1:0]  ch_oh_o,
    output logic [NUM_BRD-1:0] brd_oh_o,
    output logic [LPB-1:0]     lin_oh_o
);
    logic [BW-1:0] brd;
    logic [PW-1:0] pos;

    always_comb begin
        ch_idx_o   = sel_word_i[WW-1 -: CW];
        brd        = sel_word_i[PW +: BW];
        pos        = sel_word_i[0 +: PW];
        line_idx_o = {brd, pos};
        ch_oh_o    = {{(NUM_CH-1){1'b0}}, 1'b1} << ch_idx_o;
        brd_oh_o   = {{(NUM_BRD-1){1'b0}}, 1'b1} << brd;
        lin_oh_o   = {{(LPB-1){1'b0}}, 1'b1} << pos;
    end
endmodule

// File: rtl/xpt_src_track.sv
module xpt_src_track #(
    parameter int NUM_LINES = 32,
    localparam int LW       = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] conn_i,
    input  logic [NUM_LINES-1:0] cd_i,
    input  logic                 off_i,
    output logic                 valid_o,
    output logic [LW-1:0]        line_o
);
    typedef struct packed {
        logic          valid;
        logic [LW-1:0] line;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [NUM_LINES-1:0] cand;
    logic [LW-1:0]        pick;

    always_comb begin
        cand = conn_i & cd_i;
        pick = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (cand[i]) pick = LW'(i);
        end
        trk_d = trk_q;
        if (off_i) begin
            trk_d.valid = 1'b0;
        end else if (trk_q.valid) begin
            if (!(cd_i[trk_q.line] && conn_i[trk_q.line])) trk_d.valid = 1'b0;
        end else if (|cand) begin
            trk_d.valid = 1'b1;
            trk_d.line  = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign valid_o = trk_q.valid;
    assign line_o  = trk_q.line;
endmodule

// File: rtl/xpt_drv_gen.sv
module xpt_drv_gen #(
    parameter int NUM_CH    = 4,
    parameter int NUM_LINES = 32,
    localparam int LW       = $clog2(NUM_LINES)
) (
    input  logic [NUM_CH*NUM_LINES-1:0] conn_i,
    input  logic [NUM_CH-1:0]           rts_i,
    input  logic [NUM_CH-1:0]           src_valid_i,
    input  logic [NUM_CH*LW-1:0]        src_line_i,
    output logic [NUM_LINES-1:0]        drv_en_o
);
    always_comb begin
        drv_en_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (conn_i[c*NUM_LINES + i] && rts_i[c] &&
                    !(src_valid_i[c] && (src_line_i[c*LW +: LW] == LW'(i))))
                    drv_en_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xpt_ctrl.sv
module xpt_ctrl #(
    parameter int NUM_CH   = 4,
    parameter int NUM_BRD  = 4,
    parameter int LPB      = 8,
    localparam int NUM_LINES = NUM_BRD * LPB,
    localparam int CW      = $clog2(NUM_CH),
    localparam int LW      = $clog2(NUM_LINES),
    localparam int WW      = CW + LW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sel_on_i,
    input  logic [WW-1:0]               sel_word_i,
    input  logic [NUM_CH-1:0]           ch_off_i,
    input  logic [NUM_CH-1:0]           rts_i,
    input  logic [NUM_LINES-1:0]        cd_i,
    output logic [NUM_CH*NUM_LINES-1:0] conn_o,
    output logic                        err_o,
    output logic [NUM_BRD-1:0]          brd_en_o,
    output logic [LPB-1:0]              lin_en_o,
    output logic [NUM_CH-1:0]           ch_sel_o,
    output logic [NUM_LINES-1:0]        drv_en_o,
    output logic [NUM_CH-1:0]           src_valid_o,
    output logic [NUM_CH*LW-1:0]        src_line_o
);
    import xpt_pkg::*;

    typedef struct packed {
        logic [NUM_CH-1:0][NUM_LINES-1:0] conn;
        logic                             err;
        logic [NUM_BRD-1:0]               brd_en;
        logic [LPB-1:0]                   lin_en;
        logic [NUM_CH-1:0]                ch_sel;
    } st_t;

    st_t st_d, st_q;

    logic [CW-1:0]      dec_ch;
    logic [LW-1:0]      dec_line;
    logic [NUM_CH-1:0]  dec_ch_oh;
    logic [NUM_BRD-1:0] dec_brd_oh;
    logic [LPB-1:0]     dec_lin_oh;
    logic               owned_other;
    on_res_e            on_res;

    xpt_sel_decode #(.NUM_CH(NUM_CH), .NUM_BRD(NUM_BRD), .LPB(LPB)) u_dec (
        .sel_word_i (sel_word_i),
        .ch_idx_o   (dec_ch),
        .line_idx_o (dec_line),
        .ch_oh_o    (dec_ch_oh),
        .brd_oh_o   (dec_brd_oh),
        .lin_oh_o   (dec_lin_oh)
    );

    always_comb begin
        owned_other = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if ((CW'(c) != dec_ch) && st_q.conn[c][dec_line]) owned_other = 1'b1;
        end

        if (!sel_on_i)              on_res = ON_NONE;
        else if (ch_off_i[dec_ch])  on_res = ON_DROP;
        else if (owned_other)       on_res = ON_REJECT;
        else                        on_res = ON_ACCEPT;

        st_d        = st_q;
        st_d.brd_en = '0;
        st_d.lin_en = '0;
        st_d.ch_sel = '0;
        case (on_res)
            ON_ACCEPT: begin
                st_d.conn[dec_ch][dec_line] = 1'b1;
                st_d.brd_en = dec_brd_oh;
                st_d.lin_en = dec_lin_oh;
                st_d.ch_sel = dec_ch_oh;
            end
            ON_REJECT: st_d.err = 1'b1;
            default: ;
        endcase

        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_off_i[c]) st_d.conn[c] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_trk
            xpt_src_track #(.NUM_LINES(NUM_LINES)) u_trk (
                .clk     (clk),
                .rst_n   (rst_n),
                .conn_i  (st_q.conn[g]),
                .cd_i    (cd_i),
                .off_i   (ch_off_i[g]),
                .valid_o (src_valid_o[g]),
                .line_o  (src_line_o[g*LW +: LW])
            );
        end
    endgenerate

    xpt_drv_gen #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_drv (
        .conn_i      (conn_o),
        .rts_i       (rts_i),
        .src_valid_i (src_valid_o),
        .src_line_i  (src_line_o),
        .drv_en_o    (drv_en_o)
    );

    assign conn_o   = st_q.conn;
    assign err_o    = st_q.err;
    assign brd_en_o = st_q.brd_en;
    assign lin_en_o = st_q.lin_en;
    assign ch_sel_o = st_q.ch_sel;
endmodule

// File: rtl/xpt_ctrl_chk.sv
module xpt_ctrl_chk #(
    parameter int NUM_CH   = 4,
    parameter int NUM_BRD  = 4,
    parameter int LPB      = 8,
    localparam int NUM_LINES = NUM_BRD * LPB,
    localparam int CW      = $clog2(NUM_CH),
    localparam int LW      = $clog2(NUM_LINES),
    localparam int WW      = CW + LW,
    localparam int NB      = NUM_CH * NUM_LINES
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sel_on_i,
    input logic [NUM_CH-1:0]    ch_off_i,
    input logic [NB-1:0]        conn_o,
    input logic                 err_o,
    input logic [NUM_BRD-1:0]   brd_en_o,
    input logic [LPB-1:0]       lin_en_o,
    input logic [NUM_CH-1:0]    ch_sel_o,
    input logic [NUM_LINES-1:0] drv_en_o,
    input logic [NUM_CH-1:0]    src_valid_o,
    input logic [NUM_CH*LW-1:0] src_line_o
);
    logic [NB-1:0]        off_exp;
    logic [NUM_LINES-1:0] used;
    logic [NUM_LINES-1:0] multi;
    logic [NUM_CH-1:0]    src_bad;

    always_comb begin
        int cnt;
        off_exp = '0;
        used    = '0;
        multi   = '0;
        src_bad = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_off_i[c]) off_exp[c*NUM_LINES +: NUM_LINES] = '1;
            used = used | conn_o[c*NUM_LINES +: NUM_LINES];
            if (src_valid_o[c] && drv_en_o[src_line_o[c*LW +: LW]]) src_bad[c] = 1'b1;
        end
        for (int i = 0; i < NUM_LINES; i++) begin
            cnt = 0;
            for (int c = 0; c < NUM_CH; c++) cnt = cnt + int'(conn_o[c*NUM_LINES + i]);
            if (cnt > 1) multi[i] = 1'b1;
        end
    end

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((conn_o & $past(conn_o & ~off_exp)) == $past(conn_o & ~off_exp)));

    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_off_i) |=> ((conn_o & $past(off_exp)) == '0));

    a_r6_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        multi == '0);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    a_r3_sel_shape: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(brd_en_o) && $onehot0(lin_en_o) && $onehot0(ch_sel_o) &&
        ((brd_en_o != '0) == (lin_en_o != '0)) && ((ch_sel_o != '0) == (brd_en_o != '0)));

    a_r3_sel_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_sel_o) |-> $past(sel_on_i));

    a_r7_drv_connected: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en_o & ~used) == '0);

    a_r8_src_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        src_bad == '0);
endmodule

bind xpt_ctrl xpt_ctrl_chk #(.NUM_CH(NUM_CH), .NUM_BRD(NUM_BRD), .LPB(LPB)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_on_i    (sel_on_i),
    .ch_off_i    (ch_off_i),
    .conn_o      (conn_o),
    .err_o       (err_o),
    .brd_en_o    (brd_en_o),
    .lin_en_o    (lin_en_o),
    .ch_sel_o    (ch_sel_o),
    .drv_en_o    (drv_en_o),
    .src_valid_o (src_valid_o),
    .src_line_o  (src_line_o)
);

// File: tb/sim_xpt_ctrl.sv
module sim_xpt_ctrl;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         sel_on_i;
    logic [6:0]   sel_word_i;
    logic [3:0]   ch_off_i;
    logic [3:0]   rts_i;
    logic [31:0]  cd_i;
    logic [127:0] conn_o;
    logic         err_o;
    logic [3:0]   brd_en_o;
    logic [7:0]   lin_en_o;
    logic [3:0]   ch_sel_o;
    logic [31:0]  drv_en_o;
    logic [3:0]   src_valid_o;
    logic [19:0]  src_line_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [127:0] exp_conn = '0;

    always #(CLK_P/2) clk = ~clk;

    xpt_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sel_on_i(sel_on_i), .sel_word_i(sel_word_i),
        .ch_off_i(ch_off_i), .rts_i(rts_i), .cd_i(cd_i), .conn_o(conn_o),
        .err_o(err_o), .brd_en_o(brd_en_o), .lin_en_o(lin_en_o), .ch_sel_o(ch_sel_o),
        .drv_en_o(drv_en_o), .src_valid_o(src_valid_o), .src_line_o(src_line_o)
    );

    function automatic logic [127:0] cbit(input int ch, input int ln);
        return 128'(1) << (ch*32 + ln);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic on_pulse(input int ch, input int brd, input int pos);
        sel_on_i   = 1'b1;
        sel_word_i = {ch[1:0], brd[1:0], pos[2:0]};
        @(negedge clk);
        sel_on_i   = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "conn", conn_o, '0);
        chk("R1", "err", 128'(err_o), 0);
        chk("R1", "selects", {brd_en_o, lin_en_o, ch_sel_o}, 0);
        chk("R1", "src_valid", 128'(src_valid_o), 0);
        chk("R1", "drv", 128'(drv_en_o), 0);
    endtask

    task automatic t_connect;
        on_pulse(2, 1, 3);
        exp_conn |= cbit(2, 11);
        chk("R2", "conn line 11", conn_o, exp_conn);
        chk("R3", "board enable", 128'(brd_en_o), 128'(4'b0010));
        chk("R3", "line enable", 128'(lin_en_o), 128'(8'h08));
        chk("R3", "channel select", 128'(ch_sel_o), 128'(4'b0100));
        chk("R6", "no error on accept", 128'(err_o), 0);
        @(negedge clk);
        chk("R3", "pulse ends", {brd_en_o, lin_en_o, ch_sel_o}, 0);
        chk("R4", "held after withdraw", conn_o, exp_conn);
        on_pulse(2, 3, 6);
        exp_conn |= cbit(2, 30);
        chk("R4", "accumulate line 30", conn_o, exp_conn);
        chk("R3", "board 3", 128'(brd_en_o), 128'(4'b1000));
        chk("R3", "pos 6", 128'(lin_en_o), 128'(8'h40));
    endtask

    task automatic t_conflict;
        on_pulse(0, 1, 3);
        chk("R6", "refused conn", conn_o, exp_conn);
        chk("R6", "refused no pulse", 128'(ch_sel_o), 0);
        chk("R6", "error set", 128'(err_o), 1);
        @(negedge clk);
        chk("R6", "error sticky", 128'(err_o), 1);
        on_pulse(2, 1, 3);
        chk("R6", "repeat same channel pulse", 128'(ch_sel_o), 128'(4'b0100));
        chk("R6", "repeat same channel conn", conn_o, exp_conn);
    endtask

    task automatic t_drive;
        rts_i = 4'b0100;
        #1;
        chk("R7", "rts ch2 drives 11,30", 128'(drv_en_o), 128'((32'd1 << 11) | (32'd1 << 30)));
        rts_i = 4'b0001;
        #1;
        chk("R7", "rts ch0 empty", 128'(drv_en_o), 0);
        rts_i = 4'b0000;
        #1;
        chk("R7", "rts off", 128'(drv_en_o), 0);
    endtask

    task automatic t_source;
        @(negedge clk);
        cd_i = (32'd1 << 11) | (32'd1 << 30);
        @(negedge clk);
        chk("R8", "src ch2 valid", 128'(src_valid_o[2]), 1);
        chk("R8", "src ch2 lowest", 128'(src_line_o[10 +: 5]), 11);
        rts_i = 4'b0100;
        #1;
        chk("R7", "source excluded", 128'(drv_en_o), 128'(32'd1 << 30));
        @(negedge clk);
        cd_i = 32'd1 << 30;
        @(negedge clk);
        chk("R8", "released after drop", 128'(src_valid_o[2]), 0);
        chk("R7", "release cycle drives all", 128'(drv_en_o), 128'((32'd1 << 11) | (32'd1 << 30)));
        @(negedge clk);
        chk("R8", "reselect valid", 128'(src_valid_o[2]), 1);
        chk("R8", "reselect line 30", 128'(src_line_o[10 +: 5]), 30);
        chk("R7", "drives 11 only", 128'(drv_en_o), 128'(32'd1 << 11));
        rts_i = 4'b0000;
    endtask

    task automatic t_multi;
        on_pulse(1, 0, 0);
        chk("R9", "ch1 select", 128'(ch_sel_o), 128'(4'b0010));
        on_pulse(1, 0, 5);
        exp_conn |= cbit(1, 0) | cbit(1, 5);
        chk("R9", "two channels hold lines", conn_o, exp_conn);
        chk("R9", "ch1 no source", 128'(src_valid_o[1]), 0);
        rts_i = 4'b0110;
        #1;
        chk("R9", "both channels drive", 128'(drv_en_o),
            128'((32'd1 << 0) | (32'd1 << 5) | (32'd1 << 11)));
        cd_i = cd_i | (32'd1 << 5);
        @(negedge clk);
        chk("R9", "ch1 source 5", 128'({src_valid_o[1], src_line_o[5 +: 5]}), 128'({1'b1, 5'd5}));
        chk("R9", "ch2 source kept", 128'({src_valid_o[2], src_line_o[10 +: 5]}), 128'({1'b1, 5'd30}));
        chk("R9", "two sources excluded", 128'(drv_en_o), 128'((32'd1 << 0) | (32'd1 << 11)));
        rts_i = 4'b0000;
    endtask

    task automatic t_off;
        sel_on_i   = 1'b1;
        sel_word_i = {2'd2, 2'd0, 3'd7};
        ch_off_i   = 4'b0100;
        @(negedge clk);
        sel_on_i   = 1'b0;
        ch_off_i   = 4'b0000;
        exp_conn[64 +: 32] = '0;
        chk("R5", "channel 2 cleared, ch1 kept", conn_o, exp_conn);
        chk("R5", "dropped On gives no pulse", 128'(ch_sel_o), 0);
        chk("R8", "off releases source", 128'(src_valid_o[2]), 0);
        chk("R9", "ch1 source untouched", 128'(src_valid_o[1]), 1);
        chk("R6", "error still sticky", 128'(err_o), 1);
        rts_i = 4'b0100;
        #1;
        chk("R5", "cleared channel drives nothing", 128'(drv_en_o), 0);
        rts_i = 4'b0000;
        on_pulse(0, 1, 3);
        exp_conn |= cbit(0, 11);
        chk("R5", "freed line taken by ch0", conn_o, exp_conn);
        chk("R5", "ch0 select", 128'(ch_sel_o), 128'(4'b0001));
        @(negedge clk);
        chk("R8", "ch2 stays without source", 128'(src_valid_o[2]), 0);
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        sel_on_i   = 1'b0;
        sel_word_i = '0;
        ch_off_i   = '0;
        rts_i      = '0;
        cd_i       = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_connect();
        t_conflict();
        t_drive();
        t_source();
        t_multi();
        t_off();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule